// File: doc/BRIEF.md
# Circuit Breaker and Cool-Down Timer

This block decides how long a power switch may stay in current limit before it is tripped off, and how long it must then rest before a restart is allowed. It works in one of two modes, chosen by a strap input that is captured once, in the first clock cycle after reset. In capacitor mode it steers a charge source and a discharge source on an external timing capacitor and reads two comparators on that capacitor, one at the upper threshold and one at the lower threshold. In counted mode it uses fixed delays in clock cycles and leaves the capacitor sources idle.

A trip raises a one-cycle pulse and clears the cool-down-done level. In capacitor mode, rest ends only after a set number of full timer cycles. The discharge that follows the trip is the first cycle. Each later cycle charges the capacitor up to the upper threshold and then discharges it down to the lower one. In counted mode, rest is a fixed number of cycles. The charge source is meant to be fifty times stronger than the discharge source, so a charge ramp is short and a discharge ramp is long. The restart logic outside the block waits for cool-down-done.

Top module: `breaker_cooldown_timer`

## Requirements
- R1: Coming out of reset, charge enable, discharge enable and the trip pulse are 0, cool-down-done is 1 and the cycle count is 0.
- R2: In capacitor mode, when idle and current limit is sampled high, charge enable is 1 from the next cycle on, for as long as the limit persists below the upper threshold.
- R3: In capacitor mode, when the upper comparator is sampled high while charging under current limit, the trip output is 1 for exactly the next cycle, and in that same cycle cool-down-done drops to 0, discharge enable becomes 1 and the cycle count is 0.
- R4: During capacitor-mode cool-down, each sampling of the lower comparator high while discharging adds one to the cycle count. Below COOL_CYCLES (8) it switches to charging until the upper comparator is high. At COOL_CYCLES, cool-down-done returns to 1 and both enables fall to 0.
- R5: In capacitor mode, if current limit ends before the upper comparator is reached, charging stops and the capacitor is discharged to the lower threshold without a trip. If the upper comparator and the end of current limit are sampled in the same cycle, the trip wins.
- R6: In counted mode, a trip is issued after TRIP_TICKS consecutive cycles of current limit in the armed state (visible TRIP_TICKS+1 cycles after the limit is first driven high from idle). Any sampled gap in the limit clears the count.
- R7: In counted mode, cool-down-done returns to 1 exactly COOL_TICKS cycles after the trip pulse, and neither capacitor enable is ever asserted.
- R8: Charge enable and discharge enable are never both 1 in the same cycle.
- R9: The mode strap (1 = counted, 0 = capacitor) is sampled only in the first cycle after reset. Later changes do not alter the behaviour.
- R10: Current limit is ignored during cool-down: no further trip occurs until cool-down-done has returned to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ilim_i | input | 1 | Current limit is active |
| int_strap_i | input | 1 | Mode strap: 1 counted delays, 0 capacitor timing |
| cap_hi_i | input | 1 | Capacitor at or above the upper threshold |
| cap_lo_i | input | 1 | Capacitor at or below the lower threshold |
| chg_en_o | output | 1 | Enable the capacitor charge source |
| dis_en_o | output | 1 | Enable the capacitor discharge source |
| trip_o | output | 1 | One-cycle breaker trip pulse |
| cool_done_o | output | 1 | Cool-down complete, restart permitted |
| cyc_cnt_o | output | CNT_W | Completed timer cycles since the last trip |

## Verification
Two decisions can collide in one cycle. The first is the upper comparator reaching its threshold, which calls for a trip. The second is current limit ending, which calls for an abort and discharge. To provoke this, the bench watches its capacitor model and releases the limit in the very cycle the model crosses the upper threshold. A trip pulse must follow, not a silent discharge. The bench also holds current limit high through each whole cool-down, so that a new charge request arrives together with every discharge-to-low event. The cycle count must keep advancing with no second trip.

// File: rtl/brk_pkg.sv
package brk_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_ARM      = 3'd1,
      ST_RELAX    = 3'd2,
      ST_TRIP_DIS = 3'd3,
      ST_COOL_CHG = 3'd4,
      ST_INT_COOL = 3'd5
   } brk_state_e;

endpackage

// File: rtl/brk_strap_latch.sv
module brk_strap_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic strap_i,
   output logic mode_o,
   output logic valid_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o  <= 1'b0;
         valid_o <= 1'b0;
      end else if (!valid_o) begin
         mode_o  <= strap_i;
         valid_o <= 1'b1;
      end
   end

endmodule

// File: rtl/brk_tick_timer.sv
module brk_tick_timer #(
   parameter int TRIP_TICKS = 200_000,
   parameter int COOL_TICKS = 90_000_000,
   localparam int TICK_MAX  = (TRIP_TICKS > COOL_TICKS) ? TRIP_TICKS : COOL_TICKS,
   localparam int TW        = $clog2(TICK_MAX + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic en_i,
   output logic at_trip_o,
   output logic at_cool_o
);

   localparam logic [TW-1:0] TRIP_LAST = TW'(TRIP_TICKS - 1);
   localparam logic [TW-1:0] COOL_LAST = TW'(COOL_TICKS - 1);
   localparam logic [TW-1:0] CNT_TOP   = TW'(TICK_MAX - 1);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr_i)
         cnt_q <= '0;
      else if (en_i && cnt_q != CNT_TOP)
         cnt_q <= cnt_q + 1'b1;
   end

   assign at_trip_o = (cnt_q == TRIP_LAST);
   assign at_cool_o = (cnt_q == COOL_LAST);

   // R6
   tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_TOP);

endmodule

// File: rtl/brk_cycle_counter.sv
module brk_cycle_counter #(
   parameter int MAX = 8,
   localparam int W  = $clog2(MAX + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o,
   output logic         last_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_o <= '0;
      else if (clr_i)
         cnt_o <= '0;
      else if (inc_i && cnt_o != W'(MAX))
         cnt_o <= cnt_o + 1'b1;
   end

   assign last_o = (cnt_o == W'(MAX - 1));

   // R4
   cyc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_o <= W'(MAX));

endmodule

// File: rtl/breaker_cooldown_timer.sv
module breaker_cooldown_timer
   import brk_pkg::*;
#(
   parameter int COOL_CYCLES  = 8,
   parameter int TRIP_TICKS   = 200_000,
   parameter int COOL_TICKS   = 90_000_000,
   parameter bit HAS_INT_MODE = 1'b1,
   localparam int CNT_W       = $clog2(COOL_CYCLES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ilim_i,
   input  logic             int_strap_i,
   input  logic             cap_hi_i,
   input  logic             cap_lo_i,
   output logic             chg_en_o,
   output logic             dis_en_o,
   output logic             trip_o,
   output logic             cool_done_o,
   output logic [CNT_W-1:0] cyc_cnt_o
);

   initial begin
      assert (COOL_CYCLES >= 1) else $error("COOL_CYCLES must be at least 1");
      assert (TRIP_TICKS >= 2)  else $error("TRIP_TICKS must be at least 2");
      assert (COOL_TICKS >= 2)  else $error("COOL_TICKS must be at least 2");
   end

   brk_state_e st_q, st_nxt;
   logic strap_mode, strap_vld, mode_int;
   logic tick_at_trip, tick_at_cool, tick_clr, tick_en;
   logic cyc_last, cyc_inc;
   logic fire_trip, fire_cool;

   brk_strap_latch u_strap (
      .clk     (clk),
      .rst_n   (rst_n),
      .strap_i (int_strap_i),
      .mode_o  (strap_mode),
      .valid_o (strap_vld)
   );

   generate
      if (HAS_INT_MODE) begin : g_int
         assign mode_int = strap_mode;
         brk_tick_timer #(
            .TRIP_TICKS (TRIP_TICKS),
            .COOL_TICKS (COOL_TICKS)
         ) u_ticks (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (tick_clr),
            .en_i      (tick_en),
            .at_trip_o (tick_at_trip),
            .at_cool_o (tick_at_cool)
         );
      end else begin : g_ext_only
         assign mode_int     = 1'b0;
         assign tick_at_trip = 1'b0;
         assign tick_at_cool = 1'b0;
      end
   endgenerate

   brk_cycle_counter #(.MAX(COOL_CYCLES)) u_cycles (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (fire_trip),
      .inc_i  (cyc_inc),
      .cnt_o  (cyc_cnt_o),
      .last_o (cyc_last)
   );

   always_comb begin
      st_nxt    = st_q;
      fire_trip = 1'b0;
      fire_cool = 1'b0;
      cyc_inc   = 1'b0;
      if (strap_vld) begin
         case (st_q)
            ST_IDLE: if (ilim_i) st_nxt = ST_ARM;
            ST_ARM: begin
               if (mode_int) begin
                  if (!ilim_i) st_nxt = ST_IDLE;
                  else if (tick_at_trip) begin
                     fire_trip = 1'b1;
                     st_nxt    = ST_INT_COOL;
                  end
               end else begin
                  if (cap_hi_i) begin
                     fire_trip = 1'b1;
                     st_nxt    = ST_TRIP_DIS;
                  end else if (!ilim_i) st_nxt = ST_RELAX;
               end
            end
            ST_RELAX: begin
               if (ilim_i)        st_nxt = ST_ARM;
               else if (cap_lo_i) st_nxt = ST_IDLE;
            end
            ST_TRIP_DIS: begin
               if (cap_lo_i) begin
                  cyc_inc = 1'b1;
                  if (cyc_last) begin
                     fire_cool = 1'b1;
                     st_nxt    = ST_IDLE;
                  end else st_nxt = ST_COOL_CHG;
               end
            end
            ST_COOL_CHG: if (cap_hi_i) st_nxt = ST_TRIP_DIS;
            ST_INT_COOL: begin
               if (tick_at_cool) begin
                  fire_cool = 1'b1;
                  st_nxt    = ST_IDLE;
               end
            end
            default: st_nxt = ST_IDLE;
         endcase
      end
   end

   assign tick_clr = ((st_q != ST_ARM) && (st_q != ST_INT_COOL)) || fire_trip ||
                     fire_cool || ((st_q == ST_ARM) && !ilim_i);
   assign tick_en  = mode_int && (((st_q == ST_ARM) && ilim_i) || (st_q == ST_INT_COOL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         trip_o      <= 1'b0;
         cool_done_o <= 1'b1;
      end else begin
         st_q   <= st_nxt;
         trip_o <= fire_trip;
         if (fire_trip)      cool_done_o <= 1'b0;
         else if (fire_cool) cool_done_o <= 1'b1;
      end
   end

   assign chg_en_o = ((st_q == ST_ARM) && !mode_int) || (st_q == ST_COOL_CHG);
   assign dis_en_o = (st_q == ST_RELAX) || (st_q == ST_TRIP_DIS);

   // R8
   src_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(chg_en_o && dis_en_o));

   // R3
   trip_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trip_o |=> !trip_o);

   // R3
   done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cool_done_o) |-> trip_o);

   // R3
   ext_trip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trip_o && !mode_int) |-> $past(cap_hi_i));

   // R4
   done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cool_done_o) && !mode_int) |-> (cyc_cnt_o == CNT_W'(COOL_CYCLES)));

   // R7
   int_no_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_int && strap_vld) |-> (!chg_en_o && !dis_en_o));

endmodule

// File: tb/tb_breaker_cooldown_timer.sv
module tb_breaker_cooldown_timer;

   localparam int NCYC  = 8;
   localparam int TRIPT = 20;
   localparam int COOLT = 150;
   localparam int CW    = $clog2(NCYC + 1);
   localparam int VHI   = 1235;
   localparam int VLO   = 210;
   localparam int ICHG  = 50;
   localparam int IDIS  = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ilim = 1'b0;
   logic strap = 1'b0;
   logic cap_hi, cap_lo;
   logic chg_en, dis_en, trip, done;
   logic [CW-1:0] cyc;

   int vcap = 0;
   int n_cmp = 0;
   int n_bad = 0;
   int n_both = 0;

   always #5 clk = ~clk;

   assign cap_hi = (vcap >= VHI);
   assign cap_lo = (vcap <= VLO);

   breaker_cooldown_timer #(
      .COOL_CYCLES (NCYC),
      .TRIP_TICKS  (TRIPT),
      .COOL_TICKS  (COOLT)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .ilim_i      (ilim),
      .int_strap_i (strap),
      .cap_hi_i    (cap_hi),
      .cap_lo_i    (cap_lo),
      .chg_en_o    (chg_en),
      .dis_en_o    (dis_en),
      .trip_o      (trip),
      .cool_done_o (done),
      .cyc_cnt_o   (cyc)
   );

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // capacitor model, 50:1 charge to discharge
   always @(negedge clk) begin
      if (!rst_n) vcap <= 0;
      else if (chg_en) vcap <= (vcap + ICHG > 3000) ? 3000 : vcap + ICHG;
      else if (dis_en) vcap <= (vcap > 0) ? vcap - IDIS : 0;
   end

   // behavioural reference: phase 0 idle, 1 armed, 2 relaxing,
   // 3 post-trip discharge, 4 cool-down charge, 5 counted cool-down
   int m_ph, m_cnt, m_cyc;
   bit m_trip, m_done, m_ok, m_int, m_live;

   always @(posedge clk) begin
      m_trip <= 1'b0;
      if (!rst_n) begin
         m_ph <= 0; m_cnt <= 0; m_cyc <= 0; m_done <= 1'b1;
         m_ok <= 1'b0; m_int <= 1'b0; m_live <= 1'b1;
      end else if (!m_ok) begin
         m_ok <= 1'b1; m_int <= strap;
      end else begin
         case (m_ph)
            0: if (ilim) m_ph <= 1;
            1: if (m_int) begin
                  if (!ilim) begin m_ph <= 0; m_cnt <= 0; end
                  else if (m_cnt == TRIPT - 1) begin
                     m_trip <= 1'b1; m_done <= 1'b0; m_ph <= 5; m_cnt <= 0; m_cyc <= 0;
                  end else m_cnt <= m_cnt + 1;
               end else begin
                  if (cap_hi) begin
                     m_trip <= 1'b1; m_done <= 1'b0; m_ph <= 3; m_cyc <= 0;
                  end else if (!ilim) m_ph <= 2;
               end
            2: if (ilim) m_ph <= 1; else if (cap_lo) m_ph <= 0;
            3: if (cap_lo) begin
                  m_cyc <= m_cyc + 1;
                  if (m_cyc + 1 == NCYC) begin m_done <= 1'b1; m_ph <= 0; end
                  else m_ph <= 4;
               end
            4: if (cap_hi) m_ph <= 3;
            default: if (m_cnt == COOLT - 1) begin
                  m_done <= 1'b1; m_ph <= 0; m_cnt <= 0;
               end else m_cnt <= m_cnt + 1;
         endcase
      end
   end

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && m_live) begin
         check("R2 chg_en", int'(chg_en), int'(!m_int && m_ph == 1 || m_ph == 4));
         check("R5 dis_en", int'(dis_en), int'(m_ph == 2 || m_ph == 3));
         check("R3 trip", int'(trip), int'(m_trip));
         check("R4 cool_done", int'(done), int'(m_done));
         check("R4 cycle count", int'(cyc), m_cyc);
         if (chg_en && dis_en) n_both++;
      end
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic do_reset(input logic mode);
      rst_n = 1'b0;
      ilim  = 1'b0;
      strap = mode;
      repeat (3) tick();
      rst_n = 1'b1;
      repeat (3) tick();
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int k;
      int trips;

      // ---------------- capacitor mode ----------------
      do_reset(1'b0);
      // R1
      check("R1 chg_en", int'(chg_en), 0);
      check("R1 dis_en", int'(dis_en), 0);
      check("R1 trip", int'(trip), 0);
      check("R1 cool_done", int'(done), 1);
      check("R1 cycle count", int'(cyc), 0);

      // R2
      ilim = 1'b1;
      tick();
      check("R2 charge starts", int'(chg_en), 1);

      // R3
      k = 0;
      while (!trip && k < 200) begin tick(); k++; end
      check("R3 trip seen", int'(trip), 1);
      check("R3 done low", int'(done), 0);
      check("R3 discharging", int'(dis_en), 1);
      check("R3 count cleared", int'(cyc), 0);
      tick();
      check("R3 single pulse", int'(trip), 0);

      // R4 and R10: limit held through cool-down
      trips = 0;
      k = 0;
      while (!done && k < 20000) begin
         tick(); k++;
         if (trip) trips++;
      end
      ilim = 1'b0;
      check("R10 no trip in cool-down", trips, 0);
      check("R4 done after cycles", int'(done), 1);
      check("R4 final count", int'(cyc), NCYC);
      tick();
      check("R4 sources off", int'(chg_en | dis_en), 0);

      // R5 abort before upper threshold
      ilim = 1'b1;
      repeat (5) tick();
      ilim = 1'b0;
      tick();
      check("R5 abort discharges", int'(dis_en), 1);
      trips = 0;
      k = 0;
      while (dis_en && k < 2000) begin
         tick(); k++;
         if (trip) trips++;
      end
      check("R5 no trip on abort", trips, 0);
      check("R5 done kept", int'(done), 1);
      check("R5 idle after abort", int'(chg_en | dis_en), 0);

      // R5 tie: upper threshold and limit release in the same cycle
      ilim = 1'b1;
      k = 0;
      while (!(cap_hi && chg_en) && k < 200) begin tick(); k++; end
      ilim = 1'b0;
      tick();
      check("R5 tie trips", int'(trip), 1);
      k = 0;
      while (!done && k < 20000) begin tick(); k++; end
      check("R4 tie cool-down done", int'(done), 1);

      // ---------------- counted mode ----------------
      do_reset(1'b1);
      strap = 1'b0;  // R9: late strap change must be ignored
      ilim = 1'b1;
      k = 0;
      while (!trip && k < 200) begin
         tick(); k++;
         if (chg_en || dis_en) check("R9 strap held", 1, 0);
      end
      check("R6 trip delay", k, TRIPT + 1);
      check("R9 stays counted", int'(chg_en | dis_en), 0);

      k = 0;
      trips = 0;
      while (!done && k < 1000) begin
         tick(); k++;
         if (trip) trips++;
         if (chg_en || dis_en) check("R7 no capacitor drive", 1, 0);
      end
      ilim = 1'b0;
      check("R7 cool-down length", k, COOLT);
      check("R10 counted no retrip", trips, 0);

      // R6 gap clears the count
      tick();
      ilim = 1'b1;
      repeat (TRIPT - 1) tick();
      check("R6 no early trip", int'(done), 1);
      ilim = 1'b0;
      tick();
      ilim = 1'b1;
      k = 0;
      while (!trip && k < 200) begin tick(); k++; end
      check("R6 delay restarts", k, TRIPT + 1);
      ilim = 1'b0;
      k = 0;
      while (!done && k < 1000) begin tick(); k++; end
      check("R7 second cool-down", k, COOLT);

      tick();
      check("R8 never both sources", n_both, 0);
      finish_run();
   end

endmodule